// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight edge-triggered interrupt inputs and raises one interrupt output toward a processor. Software reaches it through a small register port with two addresses, a command address and a data address, plus a chip select, read and write strobes and an 8-bit data bus. Inside it keeps three 8-bit registers: pending requests, levels in service and a mask. Input 0 always has the highest priority and input 7 the lowest.

Before use, software sends a start word to the command address. That word arms a fixed three-step sequence on the data address. Once the sequence is complete, data-address accesses reach the mask register. Command-address writes then act as commands: a poll command, a read-select command and a non-specific end-of-interrupt. A poll read returns the winning level and acknowledges it, so the processor needs no separate acknowledge cycle. The second word of the sequence is the cascade setting. It is presented on an output so that neighbouring logic can tell a master (slave on input 2) from a slave (identity 2).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` is 0. A command-address read returns the request register (0x00). A data-address read returns the mask (0xFF).
- R2: A command write with bit 4 set (0x11) does four things: it sets the mask to 0xFF, clears the request and in-service registers, selects the request register for reads, and starts the setup sequence. The next three data writes are, in order, the vector base, the cascade word and the mode word (0x01). The cascade word appears on `cascade_cfg` (0x04 for a master, 0x02 for a slave). Only a data write after the third one reaches the mask.
- R3: A rising edge on `irq_in[i]` sets request bit i, even when that input is masked. An input that stays high does not set the bit again once it has been acknowledged.
- R4: Outside the setup sequence, a data write loads the mask and a data read returns it. A set mask bit keeps that input from raising `int_out` and from winning a poll.
- R5: `int_out` is 1 exactly when some unmasked request has a lower index than every bit in service. It follows the register state one clock later.
- R6: A command write of 0x0C arms poll mode. The next command-address read returns 0x80 OR'ed with the lowest-index unmasked pending level in bits 2:0. That read also moves the level from the request register into the in-service register.
- R7: A poll read with no unmasked request pending returns 0x07 (bit 7 clear) and leaves the in-service register unchanged. Software detects the spurious case because in-service bit 7 stays clear.
- R8: A command write of 0x0B makes every later command-address read return the in-service register, until it is changed. A command write of 0x0A selects the request register again.
- R9: A command write of 0x20 (non-specific end-of-interrupt) clears only the lowest-index bit that is set in the in-service register.
- R10: Poll mode covers a single read. The read after it returns the selected register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, qualifies the read and write strobes |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| a0 | input | 1 | Address: 0 is the command address, 1 is the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after the read strobe |
| irq_in | input | 8 | Interrupt request inputs, rising-edge sensitive |
| int_out | output | 1 | Interrupt output to the processor |
| cascade_cfg | output | 8 | Cascade word taken from the setup sequence |

## Verification
A wrong in-service state shows up at the ports within one cycle, either as an `int_out` level that disagrees with the priority rule or as a wrong level in the next poll byte. A wrong request or mask state shows up as soon as software reads the register selected by 0x0A, or reads the data address. The setup sequencer can only be observed through the data address and `cascade_cfg`. The tests therefore check that the cascade word lands in `cascade_cfg` and that only the fourth data write changes the mask. The spurious case is covered by checking that the poll byte returns 0x07 and that the in-service read returns 0x00 straight after it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VEC  = 2'd1,
    SEQ_CAS  = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_t;

  localparam logic [7:0] CMD_EOI_NS = 8'h20;
endpackage

// File: rtl/pic_edge_detect.sv
module pic_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/pic_first_set.sv
module pic_first_set #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              a0,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NLINES-1:0] irq_in,
  output logic              int_out,
  output logic [DW-1:0]     cascade_cfg
);
  import prio_irq_pkg::*;

  localparam int LW  = $clog2(NLINES);
  localparam int PAD = DW - 1 - LW;

  seq_state_t        seq_q;
  logic [NLINES-1:0] irr_q, isr_q, imr_q;
  logic              sel_isr_q, poll_q;

  logic [NLINES-1:0] rise, pend, ack_vec, eoi_vec, irr_d, isr_d;
  logic              p_found, s_found;
  logic [LW-1:0]     p_idx, s_idx;
  logic              wr_cmd, wr_dat, rd_cmd, rd_dat;
  logic              start, ocw_sel, eoi, poll_rd, int_nxt;
  logic [DW-1:0]     poll_byte;

  pic_edge_detect #(.N(NLINES)) u_edge (
    .clk(clk), .rst(rst), .din(irq_in), .rise(rise)
  );

  assign pend = irr_q & ~imr_q;

  pic_first_set #(.N(NLINES), .LW(LW)) u_pend_pri (
    .vec(pend), .found(p_found), .idx(p_idx)
  );
  pic_first_set #(.N(NLINES), .LW(LW)) u_isr_pri (
    .vec(isr_q), .found(s_found), .idx(s_idx)
  );

  always_comb begin
    wr_cmd  = cs && wr && !a0;
    wr_dat  = cs && wr && a0;
    rd_cmd  = cs && rd && !a0;
    rd_dat  = cs && rd && a0;
    start   = wr_cmd && wdata[4];
    ocw_sel = wr_cmd && (wdata[4:3] == 2'b01);
    eoi     = wr_cmd && (wdata == CMD_EOI_NS);
    poll_rd = rd_cmd && poll_q;
    ack_vec = '0;
    eoi_vec = '0;
    if (poll_rd && p_found) ack_vec[p_idx] = 1'b1;
    if (eoi && s_found)     eoi_vec[s_idx] = 1'b1;
    irr_d = start ? '0 : ((irr_q & ~ack_vec) | rise);
    isr_d = start ? '0 : ((isr_q | ack_vec) & ~eoi_vec);
    poll_byte = p_found ? {1'b1, PAD'(0), p_idx} : {1'b0, PAD'(0), {LW{1'b1}}};
    int_nxt = (seq_q == SEQ_IDLE) && p_found && (!s_found || (p_idx < s_idx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q       <= SEQ_IDLE;
      irr_q       <= '0;
      isr_q       <= '0;
      imr_q       <= '1;
      sel_isr_q   <= 1'b0;
      poll_q      <= 1'b0;
      cascade_cfg <= '0;
      rdata       <= '0;
      int_out     <= 1'b0;
    end else begin
      int_out <= int_nxt;
      irr_q   <= irr_d;
      isr_q   <= isr_d;

      if (start) begin
        seq_q     <= SEQ_VEC;
        imr_q     <= '1;
        sel_isr_q <= 1'b0;
        poll_q    <= 1'b0;
      end else if (ocw_sel) begin
        poll_q <= wdata[2];
        if (wdata[1]) sel_isr_q <= wdata[0];
      end else if (poll_rd) begin
        poll_q <= 1'b0;
      end

      if (wr_dat) begin
        case (seq_q)
          SEQ_VEC:  seq_q <= SEQ_CAS;
          SEQ_CAS: begin
            seq_q       <= SEQ_MODE;
            cascade_cfg <= wdata;
          end
          SEQ_MODE: seq_q <= SEQ_IDLE;
          default:  imr_q <= wdata[NLINES-1:0];
        endcase
      end

      if (rd_dat)       rdata <= imr_q;
      else if (poll_rd) rdata <= poll_byte;
      else if (rd_cmd)  rdata <= sel_isr_q ? isr_q : irr_q;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NLINES = 8,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              wr,
  input logic              rd,
  input logic              a0,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic              int_out,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] isr,
  input logic [NLINES-1:0] imr,
  input logic              poll,
  input logic              seq_idle
);
  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr & ~imr) != '0)); // R5

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && a0 && seq_idle) |=> (imr == $past(wdata[NLINES-1:0]))); // R4

  AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !a0 && wdata == 8'h20 && isr != '0)
      |=> ($countones(isr) == $countones($past(isr)) - 1)); // R9

  AST_POLL_ACKS: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !a0 && poll && (irr & ~imr) != '0)
      |=> (rdata[7] && $countones(isr) == $countones($past(isr)) + 1)); // R6

  AST_SPURIOUS_POLL: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && !a0 && poll && (irr & ~imr) == '0)
      |=> (!rdata[7] && $stable(isr))); // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && !a0 && wdata[4])
      |=> (imr == '1 && isr == '0 && irr == '0)); // R2
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .a0(a0),
  .wdata(wdata), .rdata(rdata), .int_out(int_out),
  .irr(irr_q), .isr(isr_q), .imr(imr_q), .poll(poll_q),
  .seq_idle(seq_q == prio_irq_pkg::SEQ_IDLE)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cs, wr, rd, a0;
  logic [7:0] wdata, rdata, irq_in, cascade_cfg;
  logic       int_out;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .a0(a0),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .cascade_cfg(cascade_cfg)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic adr, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; a0 = adr; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic adr, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; a0 = adr;
    @(negedge clk);
    v = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    bus_rd(1'b0, v); chk("R1 request reg", v, 8'h00);
    bus_rd(1'b1, v); chk("R1 mask", v, 8'hFF);
  endtask

  task automatic t_setup_master();
    logic [7:0] v;
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, 8'h00);
    bus_wr(1'b1, 8'h04);
    bus_wr(1'b1, 8'h01);
    chk("R2 cascade master", cascade_cfg, 8'h04);
    bus_rd(1'b1, v); chk("R2 mask untouched by sequence", v, 8'hFF);
    bus_wr(1'b1, 8'h00);
    bus_rd(1'b1, v); chk("R4 mask load", v, 8'h00);
  endtask

  task automatic t_edge_poll();
    logic [7:0] v;
    irq_in = 8'h20; idle(2);
    bus_rd(1'b0, v); chk("R3 edge sets request", v, 8'h20);
    chk("R5 int_out raised", {7'd0, int_out}, 8'h01);
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R6 poll level 5", v, 8'h85);
    bus_rd(1'b0, v); chk("R10 poll once, R3 request cleared", v, 8'h00);
    idle(2);
    chk("R5 int_out drops while serviced", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_priority_eoi();
    logic [7:0] v;
    irq_in = 8'h60; idle(2);
    chk("R5 lower priority blocked", {7'd0, int_out}, 8'h00);
    irq_in = 8'h62; idle(2);
    chk("R5 higher priority raises", {7'd0, int_out}, 8'h01);
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R6 poll picks level 1", v, 8'h81);
    bus_wr(1'b0, 8'h0B);
    bus_rd(1'b0, v); chk("R8 isr read", v, 8'h22);
    bus_rd(1'b0, v); chk("R8 isr select persists", v, 8'h22);
    bus_wr(1'b0, 8'h20);
    bus_rd(1'b0, v); chk("R9 eoi clears lowest index", v, 8'h20);
    bus_wr(1'b0, 8'h20);
    bus_rd(1'b0, v); chk("R9 second eoi", v, 8'h00);
    idle(2);
    chk("R5 pending level 6 raises", {7'd0, int_out}, 8'h01);
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R6 poll level 6", v, 8'h86);
    bus_wr(1'b0, 8'h20);
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R7 empty poll byte", v, 8'h07);
    bus_rd(1'b0, v); chk("R7 isr bit 7 clear", v, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    irq_in = 8'h00; idle(2);
    bus_wr(1'b1, 8'h08);
    irq_in = 8'h08; idle(2);
    chk("R4 masked input silent", {7'd0, int_out}, 8'h00);
    bus_rd(1'b1, v); chk("R4 mask read", v, 8'h08);
    bus_wr(1'b0, 8'h0A);
    bus_rd(1'b0, v); chk("R3 R8 masked request recorded", v, 8'h08);
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R4 masked level not polled", v, 8'h07);
    bus_wr(1'b1, 8'h00); idle(2);
    chk("R4 unmask raises", {7'd0, int_out}, 8'h01);
  endtask

  task automatic t_setup_slave();
    logic [7:0] v;
    bus_wr(1'b0, 8'h11);
    bus_rd(1'b0, v); chk("R2 start clears request", v, 8'h00);
    bus_wr(1'b1, 8'h08);
    bus_wr(1'b1, 8'h02);
    bus_wr(1'b1, 8'h01);
    chk("R2 cascade slave", cascade_cfg, 8'h02);
    bus_rd(1'b1, v); chk("R2 start sets mask", v, 8'hFF);
    idle(2);
    chk("R2 int_out low after restart", {7'd0, int_out}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs = 1'b0; wr = 1'b0; rd = 1'b0; a0 = 1'b0;
    wdata = 8'h00; irq_in = 8'h00;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_setup_master();
    t_edge_poll();
    t_priority_eoi();
    t_spurious();
    t_mask();
    t_setup_slave();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule